// File: doc/BRIEF.md
# Dual Down-Counter Timer Block

This block places two identical down-counting timers behind one 4 KB register window on a simple single-cycle register bus. Byte offsets in the lowest 32 bytes reach the first timer; the next 32 bytes reach the second timer, rebased so that both timers see the same register layout. The top 32 bytes of the window hold a fixed, read-only table of eight identification bytes. Every other location reads as zero and ignores writes.

Each timer owns a tick-enable input, so the two can count at unrelated rates derived outside the block (nominally 1 MHz each). A timer counts down on enabled ticks through an optional divide-by-16 or divide-by-256 prescaler. It runs in free-running, periodic or one-shot mode, with a 16-bit or 32-bit counter. It raises a sticky interrupt flag when the count steps from one to zero. The two masked interrupts are merged into one registered request line.

Top module: `dualTimerWrap`

## Requirements
- R1: Only word-aligned byte offsets 0x00 to 0x1F (address bits [1:0] zero) reach the first timer, with register index taken from address bits [4:2].
- R2: Word-aligned offsets 0x20 to 0x3F reach the second timer at index bits [4:2], so 0x20 is its load register. Its state is fully separate from the first timer.
- R3: Per-timer layout by index: 0 load value (write also loads the count), 1 current count (read-only), 2 control byte, 3 interrupt clear (write-only), 4 raw flag, 5 masked flag, 6 load value (write leaves the count alone). After reset, control reads 0x20 and load and count read 0.
- R4: Control bit 7 enables counting. Bits [3:2] select the prescale: 1 steps every 16th tick, 2 every 256th, other codes every tick. A control write restarts the prescaler. A step at zero halts when bit 0 (one-shot) is set, reloads the load value when bit 6 (periodic) is set, and otherwise reloads all ones. Any other step decrements. Bit 1 selects a 32-bit count, and clear selects 16 bits. A load write in the same cycle overrides the step.
- R5: The raw flag (bit 0 of index 4) sets on a step from count 1 to 0. A write to index 3 clears it, and a set in the same cycle wins. Index 5 returns the raw flag ANDed with control bit 5.
- R6: Word-aligned reads of 0xFE0, 0xFE4 … 0xFFC return 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in the low byte, with the upper bits zero.
- R7: Reads of 0xF00, 0xF04, any other offset from 0x40 to 0xFDF, and any unaligned offset return zero.
- R8: Writes at offsets from 0x40 up, unaligned writes, and writes to indexes 1, 4, 5 and 7 change no state.
- R9: `irqOut` equals the OR of both timers' masked flags, registered, one cycle late.
- R10: Read data appears on `busRdata` in the cycle after the read request and is zero in every cycle that follows no read.
- R11: `tickEn[i]` advances only timer i, so each timer counts at its own rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (12) | Byte offset in the window |
| busWrEn | input | 1 | Write request for this cycle |
| busRdEn | input | 1 | Read request for this cycle |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Registered read data |
| tickEn | input | NUM_TIMERS (2) | Per-timer count tick enable |
| irqOut | output | 1 | Combined registered interrupt request |

## Verification
A register write takes effect on the edge that samples it, and a read request is answered on `busRdata` after the next edge. A count step on the edge where `tickEn` is high shows up in a read issued on the following cycle. The raw flag is set on the step edge, and the masked flag follows it without delay, so `irqOut` rises one edge after the raw flag. The bench keeps a behavioural model that updates at each rising edge from the inputs presented there. It compares `busRdata` and `irqOut` with that model at every falling edge. Directed reads are also sampled on the falling edge after their request edge.

// File: rtl/dt_pkg.sv
package dt_pkg;

  // Each timer occupies a 32-byte window; index sits in address bits [4:2]
  localparam int WIN_LSB = 5;

  // Control byte bit positions (software decodes these)
  localparam int CTRL_ONESHOT  = 0;
  localparam int CTRL_WIDE     = 1;
  localparam int CTRL_DIV_LSB  = 2;
  localparam int CTRL_IE       = 5;
  localparam int CTRL_PERIODIC = 6;
  localparam int CTRL_EN       = 7;
  localparam logic [7:0] CTRL_RESET = 8'h20;

  typedef enum logic [2:0] {
    REG_LOAD  = 3'd0,
    REG_COUNT = 3'd1,
    REG_CTRL  = 3'd2,
    REG_ICLR  = 3'd3,
    REG_RAW   = 3'd4,
    REG_MSK   = 3'd5,
    REG_BGLD  = 3'd6,
    REG_NONE  = 3'd7
  } dt_reg_e;

  typedef struct packed {
    logic wrLoad;
    logic wrBgLoad;
    logic wrCtrl;
    logic wrIntClr;
  } dt_wrStb_t;

  typedef struct packed {
    logic       rdTmr;
    logic       rdId;
    logic [2:0] wordIdx;
  } dt_rdStb_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0:    idByte = 8'h04;
      3'd1:    idByte = 8'h18;
      3'd2:    idByte = 8'h14;
      3'd3:    idByte = 8'h00;
      3'd4:    idByte = 8'h0D;
      3'd5:    idByte = 8'hF0;
      3'd6:    idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dt_timerCore.sv
module dt_timerCore
  import dt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  dt_wrStb_t        wrStb,
  input  logic [CNT_W-1:0] wdata,
  input  dt_reg_e          regIdx,
  output logic [CNT_W-1:0] rdVal,
  output logic             irqMasked
);

  localparam int HALF_W   = PRE_W / 2;
  localparam int NARROW_W = 16;

  logic [7:0]       ctrlReg;
  logic [CNT_W-1:0] loadReg;
  logic [CNT_W-1:0] countReg;
  logic [PRE_W-1:0] preCnt;
  logic             rawIrq;

  logic             running;
  logic             oneShot;
  logic             periodic;
  logic             wide;
  logic [1:0]       divSel;
  logic             step;
  logic             atZero;
  logic             hitOne;
  logic [CNT_W-1:0] cntMask;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] nextCount;

  assign running  = ctrlReg[CTRL_EN];
  assign oneShot  = ctrlReg[CTRL_ONESHOT];
  assign periodic = ctrlReg[CTRL_PERIODIC];
  assign wide     = ctrlReg[CTRL_WIDE];
  assign divSel   = ctrlReg[CTRL_DIV_LSB +: 2];

  assign cntMask   = wide ? {CNT_W{1'b1}} : CNT_W'({NARROW_W{1'b1}});
  assign reloadVal = (periodic ? loadReg : {CNT_W{1'b1}}) & cntMask;
  assign atZero    = (countReg == '0);
  assign hitOne    = (countReg == CNT_W'(1));

  always_comb begin
    case (divSel)
      2'd1:    step = running && tickEn && (&preCnt[HALF_W-1:0]);
      2'd2:    step = running && tickEn && (&preCnt);
      default: step = running && tickEn;
    endcase
  end

  always_comb begin
    nextCount = countReg;
    if (wrStb.wrLoad) begin
      nextCount = wdata & cntMask;
    end else if (step) begin
      if (atZero) begin
        if (!oneShot) nextCount = reloadVal;
      end else begin
        nextCount = (countReg - CNT_W'(1)) & cntMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_RESET;
      loadReg  <= '0;
      countReg <= '0;
      preCnt   <= '0;
      rawIrq   <= 1'b0;
    end else begin
      countReg <= nextCount;
      if (wrStb.wrCtrl) ctrlReg <= wdata[7:0];
      if (wrStb.wrLoad || wrStb.wrBgLoad) loadReg <= wdata;
      if (wrStb.wrCtrl) preCnt <= '0;
      else if (running && tickEn) preCnt <= preCnt + PRE_W'(1);
      if (step && hitOne && !wrStb.wrLoad) rawIrq <= 1'b1;
      else if (wrStb.wrIntClr) rawIrq <= 1'b0;
    end
  end

  assign irqMasked = rawIrq & ctrlReg[CTRL_IE];

  always_comb begin
    case (regIdx)
      REG_LOAD, REG_BGLD: rdVal = loadReg;
      REG_COUNT:          rdVal = countReg;
      REG_CTRL:           rdVal = CNT_W'(ctrlReg);
      REG_RAW:            rdVal = CNT_W'(rawIrq);
      REG_MSK:            rdVal = CNT_W'(irqMasked);
      default:            rdVal = '0;
    endcase
  end

endmodule

// File: rtl/dt_busCtrl.sv
module dt_busCtrl
  import dt_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = 12,
  parameter int SEL_W      = 1
) (
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  output dt_wrStb_t [NUM_TIMERS-1:0] wrStb,
  output dt_rdStb_t                  rdStb,
  output logic [SEL_W-1:0]           tmrSel
);

  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] winIdx;
  logic             aligned;
  logic             inTmr;
  logic             inId;
  dt_reg_e          regSel;

  assign winIdx  = busAddr[ADDR_W-1:WIN_LSB];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign inTmr   = aligned && (winIdx < WIN_W'(NUM_TIMERS));
  assign inId    = aligned && (&winIdx);
  assign regSel  = dt_reg_e'(busAddr[WIN_LSB-1:2]);
  assign tmrSel  = winIdx[SEL_W-1:0];

  assign rdStb.rdTmr   = busRdEn && inTmr;
  assign rdStb.rdId    = busRdEn && inId;
  assign rdStb.wordIdx = busAddr[WIN_LSB-1:2];

  always_comb begin
    for (int t = 0; t < NUM_TIMERS; t++) begin
      wrStb[t] = '0;
      if (busWrEn && inTmr && (winIdx == WIN_W'(t))) begin
        case (regSel)
          REG_LOAD: wrStb[t].wrLoad   = 1'b1;
          REG_BGLD: wrStb[t].wrBgLoad = 1'b1;
          REG_CTRL: wrStb[t].wrCtrl   = 1'b1;
          REG_ICLR: wrStb[t].wrIntClr = 1'b1;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dt_dataPath.sv
module dt_dataPath
  import dt_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_TIMERS-1:0]      tickEn,
  input  dt_wrStb_t [NUM_TIMERS-1:0] wrStb,
  input  dt_rdStb_t                  rdStb,
  input  logic [SEL_W-1:0]           tmrSel,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       irqOut,
  output logic [NUM_TIMERS-1:0]      timerIrq
);

  logic [DATA_W-1:0] tmrRd [NUM_TIMERS];
  logic [DATA_W-1:0] readMux;

  for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_core
    dt_timerCore #(.CNT_W(DATA_W)) u_core (
      .clk      (clk),
      .rstN     (rstN),
      .tickEn   (tickEn[gi]),
      .wrStb    (wrStb[gi]),
      .wdata    (busWdata),
      .regIdx   (dt_reg_e'(rdStb.wordIdx)),
      .rdVal    (tmrRd[gi]),
      .irqMasked(timerIrq[gi])
    );
  end

  always_comb begin
    readMux = '0;
    if (rdStb.rdTmr) readMux = tmrRd[tmrSel];
    else if (rdStb.rdId) readMux = DATA_W'(idByte(rdStb.wordIdx));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      irqOut   <= 1'b0;
    end else begin
      busRdata <= readMux;
      irqOut   <= |timerIrq;
    end
  end

endmodule

// File: rtl/dualTimerWrap.sv
module dualTimerWrap
  import dt_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_TIMERS-1:0] tickEn,
  output logic                  irqOut
);

  localparam int SEL_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

  dt_wrStb_t [NUM_TIMERS-1:0] wrStb;
  dt_rdStb_t                  rdStb;
  logic [SEL_W-1:0]           tmrSel;
  logic [NUM_TIMERS-1:0]      timerIrq;

  dt_busCtrl #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .wrStb  (wrStb),
    .rdStb  (rdStb),
    .tmrSel (tmrSel)
  );

  dt_dataPath #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .wrStb   (wrStb),
    .rdStb   (rdStb),
    .tmrSel  (tmrSel),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irqOut  (irqOut),
    .timerIrq(timerIrq)
  );

endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busRdEn,
  input logic [DATA_W-1:0]     busRdata,
  input logic                  irqOut,
  input logic [NUM_TIMERS-1:0] timerIrq
);

  localparam logic [ADDR_W-1:0] ID_FIRST = {{(ADDR_W-5){1'b1}}, 5'b0};
  localparam logic [ADDR_W-1:0] ID_LAST  = {{(ADDR_W-2){1'b1}}, 2'b0};
  localparam logic [ADDR_W-1:0] ITEST_A  = ADDR_W'(12'hF00);
  localparam logic [ADDR_W-1:0] ITEST_B  = ADDR_W'(12'hF04);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busRdEn) |-> (busRdata == '0));

  assert_id_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && busRdEn && (busAddr == ID_FIRST)) |-> (busRdata == DATA_W'(8'h04)));

  assert_id_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && busRdEn && (busAddr == ID_LAST)) |-> (busRdata == DATA_W'(8'hB1)));

  assert_itest_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && busRdEn && ((busAddr == ITEST_A) || (busAddr == ITEST_B))) |-> (busRdata == '0));

  assert_irq_merge_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (irqOut == $past(|timerIrq)));

endmodule

bind dualTimerWrap dt_checker #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busRdEn (busRdEn),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .timerIrq(timerIrq)
);

// File: tb/sim_dualTimerWrap.sv
module sim_dualTimerWrap;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  tickEn = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dualTimerWrap u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .irqOut(irqOut)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  idTab [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
  logic [7:0]  mCtrl [2];
  logic [31:0] mLoad [2];
  logic [31:0] mCnt  [2];
  logic [7:0]  mPre  [2];
  logic        mRaw  [2];
  logic [31:0] expRd = '0;
  logic        expIrq = 1'b0;
  logic [11:0] lastAddr = '0;
  logic        lastRd = 1'b0;
  logic        checkOn = 1'b0;

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    int w;
    w = int'(a >> 5);
    if (a[1:0] != 2'b00) return 32'h0;
    if (w < 2) begin
      case (a[4:2])
        3'd0, 3'd6: return mLoad[w];
        3'd1:       return mCnt[w];
        3'd2:       return {24'h0, mCtrl[w]};
        3'd4:       return {31'h0, mRaw[w]};
        3'd5:       return {31'h0, mRaw[w] & mCtrl[w][5]};
        default:    return 32'h0;
      endcase
    end
    if (a >= 12'hFE0) return {24'h0, idTab[a[4:2]]};
    return 32'h0;
  endfunction

  function automatic string tagFor(input logic rd, input logic [11:0] a);
    if (!rd) return "R10";
    if (a[1:0] != 2'b00) return "R7";
    if (a < 12'h020) begin
      if (a[4:2] == 3'd1) return "R4";
      if (a[4:2] == 3'd4 || a[4:2] == 3'd5) return "R5";
      return "R1";
    end
    if (a < 12'h040) return "R2";
    if (a >= 12'hFE0) return "R6";
    return "R7";
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mCtrl[i] = 8'h20; mLoad[i] = 0; mCnt[i] = 0; mPre[i] = 0; mRaw[i] = 0;
      end
      expRd = 0; expIrq = 0; lastRd = 0;
      checkOn = 1'b1;
    end else begin
      expRd    = busRdEn ? modelRead(busAddr) : 32'h0;
      expIrq   = (mRaw[0] & mCtrl[0][5]) | (mRaw[1] & mCtrl[1][5]);
      lastAddr = busAddr;
      lastRd   = busRdEn;
      for (int i = 0; i < 2; i++) begin
        logic [7:0]  oc;
        logic [31:0] oLoad, oCnt, msk;
        logic [7:0]  oPre;
        logic        hit, stp, setR;
        logic [2:0]  idx;
        oc = mCtrl[i]; oLoad = mLoad[i]; oCnt = mCnt[i]; oPre = mPre[i];
        hit = busWrEn && (busAddr[1:0] == 2'b00) && (int'(busAddr >> 5) == i);
        idx = busAddr[4:2];
        msk = oc[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        if (oc[3:2] == 2'd1)      stp = tickEn[i] && oc[7] && (oPre[3:0] == 4'hF);
        else if (oc[3:2] == 2'd2) stp = tickEn[i] && oc[7] && (oPre == 8'hFF);
        else                      stp = tickEn[i] && oc[7];
        setR = 1'b0;
        if (hit && idx == 3'd0) mCnt[i] = busWdata & msk;
        else if (stp) begin
          if (oCnt == 0) begin
            if (!oc[0]) mCnt[i] = (oc[6] ? oLoad : 32'hFFFF_FFFF) & msk;
          end else begin
            mCnt[i] = (oCnt - 1) & msk;
            setR = (oCnt == 1);
          end
        end
        if (hit && idx == 3'd2) begin
          mCtrl[i] = busWdata[7:0]; mPre[i] = 0;
        end else if (tickEn[i] && oc[7]) mPre[i] = oPre + 8'd1;
        if (hit && (idx == 3'd0 || idx == 3'd6)) mLoad[i] = busWdata;
        if (setR) mRaw[i] = 1'b1;
        else if (hit && idx == 3'd3) mRaw[i] = 1'b0;
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (checkOn) begin
      checks++;
      if (busRdata !== expRd) begin
        errors++;
        $display("FAIL %s model read addr %h: actual %h expected %h",
                 tagFor(lastRd, lastAddr), lastAddr, busRdata, expRd);
      end
      checks++;
      if (irqOut !== expIrq) begin
        errors++;
        $display("FAIL R9 model irqOut: actual %b expected %b", irqOut, expIrq);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrEn = 1'b1; busRdEn = 1'b0;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    busAddr = a; busRdEn = 1'b1; busWrEn = 1'b0;
    @(negedge clk);
    busRdEn = 1'b0;
    checks++;
    if (busRdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: actual %h expected %h", tag, a, busRdata, exp);
    end
  endtask

  task automatic irqChk(input logic exp, input string tag);
    checks++;
    if (irqOut !== exp) begin
      errors++;
      $display("FAIL %s irqOut: actual %b expected %b", tag, irqOut, exp);
    end
  endtask

  task automatic ticks(input logic [1:0] m, input int n);
    tickEn = m;
    repeat (n) @(negedge clk);
    tickEn = 2'b00;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    rdChk(12'h008, 32'h20, "R3");      // reset control
    rdChk(12'h004, 32'h0,  "R3");      // reset count
    rdChk(12'h028, 32'h20, "R2");
    for (int i = 0; i < 8; i++) rdChk(12'hFE0 + 12'(4 * i), {24'h0, idTab[i]}, "R6");
    rdChk(12'hF00, 32'h0, "R7");
    rdChk(12'hF04, 32'h0, "R7");
    rdChk(12'h040, 32'h0, "R7");
    rdChk(12'h009, 32'h0, "R7");       // unaligned

    wr(12'h000, 32'h1234);
    wr(12'h040, 32'hDEAD);             // beyond timers
    wr(12'h001, 32'h55);               // unaligned
    wr(12'h004, 32'h77);               // read-only count
    rdChk(12'h000, 32'h1234, "R8");
    rdChk(12'h004, 32'h1234, "R8");
    rdChk(12'h020, 32'h0,    "R2");

    wr(12'h038, 32'h99);               // second timer, index 6
    rdChk(12'h038, 32'h99, "R2");
    rdChk(12'h020, 32'h99, "R3");
    rdChk(12'h024, 32'h0,  "R3");      // count untouched by index 6

    // periodic, 32-bit, divide by 1, interrupt enabled
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hE2);
    ticks(2'b01, 3);
    rdChk(12'h004, 32'd0, "R4");
    rdChk(12'h010, 32'd1, "R5");
    rdChk(12'h014, 32'd1, "R5");
    irqChk(1'b1, "R9");
    rdChk(12'h024, 32'd0, "R11");
    ticks(2'b01, 1);
    rdChk(12'h004, 32'd3, "R4");       // periodic reload
    wr(12'h00C, 32'h0);
    rdChk(12'h010, 32'd0, "R5");
    irqChk(1'b0, "R9");

    // interrupt masked by control bit 5
    wr(12'h008, 32'hC2);
    ticks(2'b01, 3);
    rdChk(12'h010, 32'd1, "R5");
    rdChk(12'h014, 32'd0, "R5");
    irqChk(1'b0, "R9");

    // second timer: one-shot, divide by 16, 16-bit
    wr(12'h020, 32'd2);
    wr(12'h028, 32'hA5);
    ticks(2'b10, 16);
    rdChk(12'h024, 32'd1, "R4");
    ticks(2'b10, 15);
    rdChk(12'h024, 32'd1, "R4");
    ticks(2'b10, 1);
    rdChk(12'h024, 32'd0, "R4");
    rdChk(12'h030, 32'd1, "R5");
    irqChk(1'b1, "R9");
    ticks(2'b10, 32);
    rdChk(12'h024, 32'd0, "R4");       // one-shot halts
    rdChk(12'h004, 32'd0, "R11");      // first timer saw no ticks

    // first timer free-running, 16-bit
    wr(12'h008, 32'h80);
    ticks(2'b01, 1);
    rdChk(12'h004, 32'h0000_FFFF, "R4");
    ticks(2'b01, 2);
    rdChk(12'h004, 32'h0000_FFFD, "R4");
    rdChk(12'h024, 32'd0, "R11");

    // mixed traffic, checked every cycle against the model
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom % 16);
      busWrEn = 1'b0; busRdEn = 1'b0;
      tickEn  = 2'($urandom);
      if (r < 6) begin
        busAddr = 12'($urandom % 64);
        busAddr[1:0] = (($urandom % 8) == 0) ? 2'b10 : 2'b00;
        busRdEn = 1'b1;
      end else if (r < 9) begin
        busAddr = 12'($urandom % 64);
        busAddr[1:0] = 2'b00;
        busWdata = (busAddr[4:2] == 3'd2) ? ($urandom & 32'hE7) : ($urandom & 32'h1F);
        busWrEn = 1'b1;
      end else if (r < 11) begin
        busAddr = 12'hFE0 + 12'(4 * ($urandom % 8));
        busRdEn = 1'b1;
      end else if (r < 12) begin
        busAddr = 12'h040 + 12'($urandom % 12'hF00);
        busWdata = $urandom;
        busWrEn = ($urandom % 2) == 0;
        busRdEn = !busWrEn;
      end
      @(negedge clk);
    end
    busWrEn = 1'b0; busRdEn = 1'b0; tickEn = 2'b00;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule